// File: doc/BRIEF.md
# LCD Frame Clock and Blink Generator

This block derives every timing event that an LCD segment driver needs from one fast source clock. It produces no derived clocks. Each output is a one-cycle enable strobe in the source domain. A power-of-two prescaler comes first. A second divider then divides by sixteen plus a programmed offset, and its ticks are grouped into frames. The group size is the number of active common phases, set by a duty code.

A blink controller counts whole frames and flips a blink phase once every half blink period. It outputs that phase and a one-cycle toggle strobe. It also outputs a blanking selector, which tells the segment driver which pixels to hide during the blanked half. The duty code is captured only while the block is disabled. Divider and blink-rate codes may change at any time, and each new code is picked up when the counter it controls next wraps.

Top module: `lcd_tick_gen`

## Requirements
- R1: While `enable` is high, `ps_tick` pulses once every 2^`cfg_ps` source cycles. Code 0 gives a pulse on every cycle, and code 15 gives one every 32768 cycles.
- R2: `div_tick` pulses once for every 16+`cfg_div` prescaler pulses, so the ratio ranges from 16 to 31.
- R3: `frame_tick` pulses once for every `cfg_duty`+1 divider pulses (1 to 8 common phases). Each frame therefore lasts 2^PS × (16+DIV) × (duty+1) source cycles.
- R4: A change of `cfg_duty` while `enable` is high has no effect on the frame length. The code is sampled only while `enable` is low.
- R5: When the blink mode is not 00, `blink_phase` inverts once every 2^(`cfg_blink_rate`+2) frames, which is half of a blink period of 2^(rate+3) frames. `blink_toggle` pulses in the same cycle as each inversion.
- R6: With blink mode 00, `blink_phase` is 0 (visible) and `blink_toggle` stays low.
- R7: `blank_sel` equals the blink mode while `blink_phase` is 1, and 00 otherwise. The encodings are 01 for the single pixel on segment 0 / common 0, 10 for segment 0 on every active common, and 11 for every pixel.
- R8: While `enable` is low, every strobe and the phase are 0 from the next cycle on, and all counters restart from zero.
- R9: A new `cfg_ps`, `cfg_div` or `cfg_blink_rate` value takes effect at the next wrap of the counter it controls. The current count period finishes with the old value.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low clears all counters |
| cfg_ps | input | 4 | Prescaler exponent |
| cfg_div | input | 4 | Divider offset added to 16 |
| cfg_duty | input | 3 | Active commons minus one |
| cfg_blink_mode | input | 2 | Blink scope (00 off, 01 one pixel, 10 segment 0 column, 11 all) |
| cfg_blink_rate | input | 3 | Blink period exponent minus three |
| ps_tick | output | 1 | Prescaler strobe |
| div_tick | output | 1 | Divider strobe |
| frame_tick | output | 1 | Frame strobe |
| blink_toggle | output | 1 | Strobe on each blink phase inversion |
| blink_phase | output | 1 | 1 during the blanked half |
| blank_sel | output | 2 | Pixel scope to blank now |

## Verification
The fastest setting (PS 0, DIV 0, duty 1) checks the divider chain with no prescaling. A mixed setting (PS 2, DIV 3, duty 2) shows whether each stage multiplies the period of the stage before it, or adds to it by mistake. The PS code 15 run shows whether the full prescaler width is honoured. Each blink mode is run with its own rate. Codes are changed both in the middle of a period and while the block is enabled, so a wrap-time reload can be told apart from an immediate reload, and a protected duty code from an unprotected one.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
   typedef enum logic [1:0] {
      BLK_OFF = 2'b00,
      BLK_ONE = 2'b01,
      BLK_COL = 2'b10,
      BLK_ALL = 2'b11
   } blink_mode_e;

   localparam int unsigned DIV_FLOOR = 16;
   localparam int unsigned BLINK_HALF_SHIFT = 2;
endpackage

// File: rtl/lcdt_stage.sv
module lcdt_stage #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          step,
   input  logic [CW-1:0] next_lim,
   output logic          tick
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_q;
   logic          wrap;

   generate
      if (CW < 1) begin : g_bad_cw
         $error("lcdt_stage: CW must be at least 1");
      end
   endgenerate

   assign wrap = step && (cnt_q == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
         tick  <= 1'b0;
      end else if (!enable) begin
         cnt_q <= '0;
         lim_q <= next_lim;
         tick  <= 1'b0;
      end else begin
         tick <= wrap;
         if (wrap) begin
            cnt_q <= '0;
            lim_q <= next_lim;
         end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R2/R3: an output pulse can only follow an input step
   p_tick_after_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(step));
   // R8: disabled stage stays silent
   p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !tick);
   // R9: count never passes the held limit
   p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_q);
endmodule

// File: rtl/lcdt_blink.sv
module lcdt_blink
   import lcdt_pkg::*;
#(
   parameter int unsigned RATE_W    = 3,
   parameter bit          BLANK_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              frame_tick,
   input  blink_mode_e       mode,
   input  logic [RATE_W-1:0] rate,
   output logic              phase,
   output logic              toggle,
   output logic [1:0]        blank_sel
);
   localparam int unsigned BCW = (2 ** RATE_W) + BLINK_HALF_SHIFT;

   logic [BCW-1:0]  cnt_q;
   logic [BCW-1:0]  lim_q;
   logic [BCW-1:0]  new_lim;
   logic [RATE_W:0] shamt;
   logic            hit;

   generate
      if (RATE_W < 1 || RATE_W > 4) begin : g_bad_rate
         $error("lcdt_blink: RATE_W out of range");
      end
   endgenerate

   assign shamt   = {1'b0, rate} + (RATE_W+1)'(BLINK_HALF_SHIFT);
   assign new_lim = (BCW'(1) << shamt) - BCW'(1);
   assign hit     = frame_tick && (cnt_q == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lim_q  <= '0;
         phase  <= 1'b0;
         toggle <= 1'b0;
      end else if (!enable) begin
         cnt_q  <= '0;
         lim_q  <= new_lim;
         phase  <= 1'b0;
         toggle <= 1'b0;
      end else begin
         toggle <= 1'b0;
         if (hit) begin
            cnt_q <= '0;
            lim_q <= new_lim;
            if (mode != BLK_OFF) begin
               phase  <= ~phase;
               toggle <= 1'b1;
            end
         end else if (frame_tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (mode == BLK_OFF) begin
            phase <= 1'b0;
         end
      end
   end

   generate
      if (BLANK_REG) begin : g_blank_reg
         logic [1:0] sel_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sel_q <= 2'b00;
            else        sel_q <= phase ? mode : BLK_OFF;
         end
         assign blank_sel = sel_q;
      end else begin : g_blank_comb
         assign blank_sel = phase ? mode : BLK_OFF;
      end
   endgenerate

   // R5: every toggle strobe coincides with an inversion of the phase
   p_toggle_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
      toggle |-> (phase != $past(phase)));
   // R5: the phase moves only on a frame boundary
   p_phase_on_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && phase != $past(phase) && $past(mode) != BLK_OFF) |-> $past(frame_tick));
   // R6: blink off keeps the visible phase and no strobe
   p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BLK_OFF) |=> (!phase && !toggle));
endmodule

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen
   import lcdt_pkg::*;
#(
   parameter int unsigned PS_W   = 4,
   parameter int unsigned DIV_W  = 4,
   parameter int unsigned DUTY_W = 3,
   parameter int unsigned RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [PS_W-1:0]   cfg_ps,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [DUTY_W-1:0] cfg_duty,
   input  logic [1:0]        cfg_blink_mode,
   input  logic [RATE_W-1:0] cfg_blink_rate,
   output logic              ps_tick,
   output logic              div_tick,
   output logic              frame_tick,
   output logic              blink_toggle,
   output logic              blink_phase,
   output logic [1:0]        blank_sel
);
   localparam int unsigned PS_CW  = (2 ** PS_W) - 1;
   localparam int unsigned DIV_CW = $clog2(DIV_FLOOR + (2 ** DIV_W));

   logic [PS_CW-1:0]  ps_lim;
   logic [DIV_CW-1:0] div_lim;
   logic [DUTY_W-1:0] duty_q;

   generate
      if (PS_W < 1 || PS_W > 5) begin : g_bad_ps
         $error("lcd_tick_gen: PS_W out of range");
      end
      if (DUTY_W < 1) begin : g_bad_duty
         $error("lcd_tick_gen: DUTY_W must be at least 1");
      end
   endgenerate

   assign ps_lim  = (PS_CW'(1) << cfg_ps) - PS_CW'(1);
   assign div_lim = DIV_CW'(DIV_FLOOR - 1) + DIV_CW'(cfg_div);

   // drive-format code is write-protected while running
   always_ff @(posedge clk) begin
      if (!rst_n)       duty_q <= '0;
      else if (!enable) duty_q <= cfg_duty;
   end

   lcdt_stage #(.CW(PS_CW)) u_ps (
      .clk(clk), .rst_n(rst_n), .enable(enable), .step(1'b1),
      .next_lim(ps_lim), .tick(ps_tick));

   lcdt_stage #(.CW(DIV_CW)) u_div (
      .clk(clk), .rst_n(rst_n), .enable(enable), .step(ps_tick),
      .next_lim(div_lim), .tick(div_tick));

   lcdt_stage #(.CW(DUTY_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .enable(enable), .step(div_tick),
      .next_lim(duty_q), .tick(frame_tick));

   lcdt_blink #(.RATE_W(RATE_W), .BLANK_REG(1'b0)) u_blink (
      .clk(clk), .rst_n(rst_n), .enable(enable), .frame_tick(frame_tick),
      .mode(blink_mode_e'(cfg_blink_mode)), .rate(cfg_blink_rate),
      .phase(blink_phase), .toggle(blink_toggle), .blank_sel(blank_sel));

   // R4: the latched duty code holds while enabled
   p_duty_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> $stable(duty_q));
   // R3: a frame strobe implies a divider strobe the cycle before
   p_frame_after_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |-> $past(div_tick));
endmodule

// File: tb/lcd_tick_gen_tb.sv
module lcd_tick_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic [3:0] cfg_ps = '0;
   logic [3:0] cfg_div = '0;
   logic [2:0] cfg_duty = '0;
   logic [1:0] cfg_blink_mode = '0;
   logic [2:0] cfg_blink_rate = '0;
   logic ps_tick, div_tick, frame_tick, blink_toggle, blink_phase;
   logic [1:0] blank_sel;

   int n_checks = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_tick_gen dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_ps(cfg_ps), .cfg_div(cfg_div),
      .cfg_duty(cfg_duty), .cfg_blink_mode(cfg_blink_mode), .cfg_blink_rate(cfg_blink_rate),
      .ps_tick(ps_tick), .div_tick(div_tick), .frame_tick(frame_tick),
      .blink_toggle(blink_toggle), .blink_phase(blink_phase), .blank_sel(blank_sel));

   // behavioural reference: periods held as integers, reloaded on wrap
   int m_ps_n, m_ps_per, m_div_n, m_div_per, m_fr_n, m_fr_per, m_bl_n, m_bl_per, m_duty;
   bit m_ps, m_div, m_fr, m_tog, m_ph;

   initial begin
      m_ps_n = 0; m_ps_per = 1; m_div_n = 0; m_div_per = 1; m_fr_n = 0; m_fr_per = 1;
      m_bl_n = 0; m_bl_per = 1; m_duty = 0;
      m_ps = 0; m_div = 0; m_fr = 0; m_tog = 0; m_ph = 0;
   end

   always @(posedge clk) begin
      bit n_ps, n_div, n_fr, n_tog;
      if (!rst_n) begin
         m_ps_n = 0; m_ps_per = 1; m_div_n = 0; m_div_per = 1; m_fr_n = 0; m_fr_per = 1;
         m_bl_n = 0; m_bl_per = 1; m_duty = 0;
         m_ps = 0; m_div = 0; m_fr = 0; m_tog = 0; m_ph = 0;
      end else if (!enable) begin
         m_duty = cfg_duty;
         m_ps_n = 0; m_ps_per = 1 << cfg_ps;
         m_div_n = 0; m_div_per = 16 + cfg_div;
         m_fr_n = 0; m_fr_per = cfg_duty + 1;
         m_bl_n = 0; m_bl_per = 1 << (cfg_blink_rate + 2);
         m_ps = 0; m_div = 0; m_fr = 0; m_tog = 0; m_ph = 0;
      end else begin
         n_ps = 0; n_div = 0; n_fr = 0; n_tog = 0;
         m_ps_n++;
         if (m_ps_n == m_ps_per) begin n_ps = 1; m_ps_n = 0; m_ps_per = 1 << cfg_ps; end
         if (m_ps) begin
            m_div_n++;
            if (m_div_n == m_div_per) begin n_div = 1; m_div_n = 0; m_div_per = 16 + cfg_div; end
         end
         if (m_div) begin
            m_fr_n++;
            if (m_fr_n == m_fr_per) begin n_fr = 1; m_fr_n = 0; m_fr_per = m_duty + 1; end
         end
         if (m_fr) begin
            m_bl_n++;
            if (m_bl_n == m_bl_per) begin
               m_bl_n = 0; m_bl_per = 1 << (cfg_blink_rate + 2);
               if (cfg_blink_mode != 2'b00) begin n_tog = 1; m_ph = ~m_ph; end
            end
         end
         if (cfg_blink_mode == 2'b00) m_ph = 0;
         m_ps = n_ps; m_div = n_div; m_fr = n_fr; m_tog = n_tog;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // compare with the model on every cycle, away from the clock edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !done) begin
         check("R1 ps_tick", ps_tick, m_ps);
         check("R2 div_tick", div_tick, m_div);
         check("R3 frame_tick", frame_tick, m_fr);
         check("R5 blink_toggle", blink_toggle, m_tog);
         check("R6 blink_phase", blink_phase, m_ph);
         check("R7 blank_sel", blank_sel, m_ph ? cfg_blink_mode : 0);
      end
   end

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   // measure the distance in cycles between two pulses of a chosen strobe
   task automatic measure(input int which, input int exp, input string tag);
      int gap = 0;
      int seen = 0;
      int limit = 3 * exp + 100;
      for (int i = 0; i < 2 * limit && seen < 2; i++) begin
         @(negedge clk);
         if (seen == 1) gap++;
         if ((which == 0 && ps_tick) || (which == 1 && div_tick) || (which == 2 && frame_tick))
            seen++;
      end
      check(tag, (seen == 2) ? gap : -1, exp);
      @(posedge clk); #2;
   endtask

   task automatic setup(input int ps, input int dv, input int dt, input int md, input int rt);
      enable = 0;
      cfg_ps = 4'(ps); cfg_div = 4'(dv); cfg_duty = 3'(dt);
      cfg_blink_mode = 2'(md); cfg_blink_rate = 3'(rt);
      run(3);
      enable = 1;
   endtask

   initial begin
      run(4);
      #1;
      // R10: reset state
      check("R10 reset outputs", {ps_tick, div_tick, frame_tick, blink_toggle, blink_phase, blank_sel}, 0);
      rst_n = 1;
      run(2);

      // fastest chain, all-pixel blink
      setup(0, 0, 0, 3, 0);
      measure(0, 1, "R1 period code 0");
      measure(2, 16, "R3 frame period ps0 div0 duty1");
      run(400);

      // R4: duty change while running is ignored
      cfg_duty = 3'd7;
      measure(2, 16, "R4 duty locked while enabled");
      // R8: disable clears outputs
      enable = 0;
      run(2);
      check("R8 outputs cleared", {ps_tick, div_tick, frame_tick, blink_toggle, blink_phase, blank_sel}, 0);
      enable = 1;
      measure(2, 128, "R3 frame period duty8");

      // mixed setting, single-pixel blink
      setup(2, 3, 1, 1, 1);
      measure(0, 4, "R1 period code 2");
      measure(1, 76, "R2 divider period 4x19");
      measure(2, 152, "R3 frame period 4x19x2");
      run(3000);
      // R9: new codes applied at wrap, compared by the model each cycle
      cfg_ps = 4'd1; cfg_div = 4'd15; cfg_blink_rate = 3'd0;
      run(500);
      measure(1, 62, "R9 divider period after reload");
      run(1500);

      // R6: blink off
      cfg_blink_mode = 2'b00;
      run(1200);
      check("R6 phase held visible", blink_phase, 0);

      // R7: column scope
      setup(0, 0, 2, 2, 0);
      run(1000);
      check("R7 blank_sel column scope", blank_sel, blink_phase ? 2 : 0);

      // R1: widest prescale
      setup(15, 0, 0, 0, 0);
      measure(0, 32768, "R1 period code 15");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int w = 0; w < WATCHDOG; w++) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule